// File: doc/BRIEF.md
# Dual-Converter Configuration SPI Master

This block lets a host configure two identical converter chips over a three-wire, half-duplex serial link. The host writes a single command word. The word carries a per-device select mask, a direction flag, a register address and a data byte. The block then shifts a 24-bit frame onto the serial data line, most significant bit first. The frame is the instruction byte, then the address byte, then the data byte.

Several devices can be selected together. A write can therefore load the same register in every selected chip in one frame, and a read collects each selected chip's reply byte into its own byte lane of the receive word. On a read the block releases the data line for the final byte. Each device's data pin reaches the block on its own input bit, so the replies do not collide.

A separate configuration write sets the serial clock divider and the active-low reset level of each device.

Top module: `dual_spi_cfg_master`

## Requirements
- R1: After reset: `busy` is 0, all `spi_cs_n` bits are 1, `spi_sclk` is 0, `sdio_oe` is 0, `dev_rst_n` is all 0 and `rx_data` is 0. The divider equals `DIV_RST` (3 by default), so the first frame lasts 196 cycles without any configuration write.
- R2: The command word has these fields: `cmd_wdata[24+i]` selects device i, bit 23 is the read flag (1 means read), bits [23:16] form the instruction byte, bits [15:8] are the address and bits [7:0] are the data. The word is taken when `cmd_we` is 1 and `busy` is 0. The block then sends bits [23:0] MSB first, so each selected device receives instruction, address and data in that order.
- R3: For the whole frame, `spi_cs_n[i]` is low exactly when select bit i is set, and unselected devices stay high. Setting both select bits makes both devices receive an identical write.
- R4: `spi_sclk` idles low. Data changes after a falling edge and is sampled on a rising edge. One half period of `spi_sclk` lasts `div+1` clock cycles. `busy` stays high for exactly 49*(div+1) cycles, counted from the edge that takes the command.
- R5: `sdio_oe` is 1 while the first 16 bits are presented. It stays 1 for all 24 bits of a write. It is 0 for the last 8 bits of a read, so the data byte of a read word is never driven. It is 0 while idle.
- R6: A read clears `rx_data`. It then shifts device i's reply, MSB first, into `rx_data[8*i+7:8*i]` for each selected device, so unselected lanes read 0. A write leaves `rx_data` unchanged.
- R7: A command written while `busy` is 1 is ignored. The frame in flight runs to its normal end, and no second frame follows.
- R8: A pulse on `cfg_we` loads `cfg_div` as the divider and `cfg_rel` as `dev_rst_n` (bit i releases device i). `dev_rst_n` changes only on such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 24+NDEV | Command word (select mask, instruction, address, data) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | DIV_W | Serial clock divider value |
| cfg_rel | input | NDEV | Device reset release bits |
| busy | output | 1 | Frame in progress |
| rx_data | output | 8*NDEV | Read result, one byte lane per device |
| dev_rst_n | output | NDEV | Active-low device resets |
| spi_cs_n | output | NDEV | Active-low chip selects |
| spi_sclk | output | 1 | Serial clock |
| sdio_out | output | 1 | Serial data toward the devices |
| sdio_oe | output | 1 | Output enable for the shared data pad |
| sdio_in | input | NDEV | Serial data from each device's pin |

## Verification
The bench builds the block with two devices, an 8-bit divider field and a reset divider of 3. It then rewrites the divider to 0 and to 5. A divider of 0 reaches the one-cycle half period, where every bus edge is also a serial clock edge. A divider of 5 shows that the frame length scales with the divider. Two devices are enough to exercise single selects, dual selects, lane packing and the clearing of an unselected lane.

// File: rtl/dual_spi_cfg_master.sv
module dual_spi_cfg_master #(
  parameter int NDEV    = 2,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_we,
  input  logic [23+NDEV:0]     cmd_wdata,
  input  logic                 cfg_we,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic [NDEV-1:0]      cfg_rel,
  output logic                 busy,
  output logic [8*NDEV-1:0]    rx_data,
  output logic [NDEV-1:0]      dev_rst_n,
  output logic [NDEV-1:0]      spi_cs_n,
  output logic                 spi_sclk,
  output logic                 sdio_out,
  output logic                 sdio_oe,
  input  logic [NDEV-1:0]      sdio_in
);
  localparam int BITS    = 24;
  localparam int LAST_PH = 2 * BITS;
  localparam int PH_W    = $clog2(LAST_PH + 1);
  localparam logic [PH_W-1:0] PH_END  = PH_W'(LAST_PH);
  localparam logic [PH_W-1:0] PH_RD   = PH_W'(32);
  localparam logic [PH_W-1:0] PH_OFF  = PH_W'(31);

  logic [DIV_W-1:0] div_q, cnt_q;
  logic [PH_W-1:0]  ph_q;
  logic [BITS-1:0]  sh_q;
  logic [NDEV-1:0]  sel_q;
  logic             rnw_q;

  assign sdio_out = sh_q[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= DIV_W'(DIV_RST);
      dev_rst_n <= '0;
      busy      <= 1'b0;
      cnt_q     <= '0;
      ph_q      <= '0;
      sh_q      <= '0;
      sel_q     <= '0;
      rnw_q     <= 1'b0;
      spi_cs_n  <= '1;
      spi_sclk  <= 1'b0;
      sdio_oe   <= 1'b0;
      rx_data   <= '0;
    end else begin
      if (cfg_we) begin
        div_q     <= cfg_div;
        dev_rst_n <= cfg_rel;
      end
      if (!busy && cmd_we) begin
        busy     <= 1'b1;
        sel_q    <= cmd_wdata[24 +: NDEV];
        rnw_q    <= cmd_wdata[23];
        sh_q     <= cmd_wdata[23:0];
        spi_cs_n <= ~cmd_wdata[24 +: NDEV];
        spi_sclk <= 1'b0;
        sdio_oe  <= 1'b1;
        cnt_q    <= '0;
        ph_q     <= '0;
        if (cmd_wdata[23]) rx_data <= '0;
      end else if (busy) begin
        if (cnt_q != div_q) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          if (ph_q == PH_END) begin
            busy     <= 1'b0;
            spi_cs_n <= '1;
            sdio_oe  <= 1'b0;
          end else begin
            ph_q <= ph_q + 1'b1;
            if (!ph_q[0]) begin
              spi_sclk <= 1'b1;
              if (rnw_q && ph_q >= PH_RD) begin
                for (int i = 0; i < NDEV; i++)
                  if (sel_q[i]) rx_data[8*i +: 8] <= {rx_data[8*i +: 7], sdio_in[i]};
              end
            end else begin
              spi_sclk <= 1'b0;
              sh_q     <= {sh_q[BITS-2:0], 1'b0};
              if (rnw_q && ph_q == PH_OFF) sdio_oe <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dual_spi_cfg_master_chk.sv
module dual_spi_cfg_master_chk #(
  parameter int NDEV = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            busy,
  input logic [NDEV-1:0] spi_cs_n,
  input logic            spi_sclk,
  input logic            sdio_oe,
  input logic [NDEV-1:0] dev_rst_n
);
  // R3
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n == {NDEV{1'b1}}));
  // R4
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);
  // R5
  idle_oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdio_oe);
  // R7
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spi_cs_n));
  // R8
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(dev_rst_n));
endmodule

bind dual_spi_cfg_master dual_spi_cfg_master_chk #(.NDEV(NDEV)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .busy(busy),
  .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .sdio_oe(sdio_oe),
  .dev_rst_n(dev_rst_n)
);

// File: tb/dual_spi_cfg_master_tb.sv
module dual_spi_cfg_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [25:0] cmd_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic [1:0]  cfg_rel = '0;
  logic        busy, spi_sclk, sdio_out, sdio_oe;
  logic [15:0] rx_data;
  logic [1:0]  dev_rst_n, spi_cs_n, sdio_in;

  int n_chk = 0, n_bad = 0;
  logic [23:0] mcap [2];
  int          mcnt [2];
  logic [7:0]  reply [2];
  int          bidx = 0;
  int          oe_bad = 0;
  logic        exp_rnw = 1'b0;

  always #5 clk = ~clk;

  dual_spi_cfg_master #(.NDEV(2), .DIV_W(8), .DIV_RST(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_rel(cfg_rel), .busy(busy),
    .rx_data(rx_data), .dev_rst_n(dev_rst_n), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .sdio_in(sdio_in)
  );

  always @(posedge spi_sclk) begin
    if (sdio_oe !== !(exp_rnw && bidx >= 16)) oe_bad <= oe_bad + 1;
    bidx <= bidx + 1;
    for (int i = 0; i < 2; i++)
      if (!spi_cs_n[i]) begin
        mcap[i] <= {mcap[i][22:0], sdio_out};
        mcnt[i] <= mcnt[i] + 1;
      end
  end

  always_comb begin
    for (int i = 0; i < 2; i++)
      sdio_in[i] = (!spi_cs_n[i] && mcnt[i] >= 16 && mcnt[i] < 24) ? reply[i][23 - mcnt[i]] : 1'b0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 2; i++) begin mcap[i] = '0; mcnt[i] = 0; end
    bidx = 0; oe_bad = 0;
  endtask

  task automatic run(input logic [25:0] cmd, output int cycles);
    clear_model();
    exp_rnw = cmd[23];
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = cmd;
    @(negedge clk); cmd_we = 1'b0;
    cycles = 0;
    while (busy) begin @(negedge clk); cycles++; end
  endtask

  task automatic set_cfg(input logic [7:0] d, input logic [1:0] r);
    @(negedge clk); cfg_we = 1'b1; cfg_div = d; cfg_rel = r;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 cs_n", 32'(spi_cs_n), 3);
    chk("R1 sclk", 32'(spi_sclk), 0);
    chk("R1 oe", 32'(sdio_oe), 0);
    chk("R1 dev_rst_n", 32'(dev_rst_n), 0);
    chk("R1 rx", 32'(rx_data), 0);
  endtask

  task automatic t_write_single();
    int c;
    run({2'b01, 8'h00, 8'h5A, 8'hC3}, c);
    chk("R1 default divider frame length", c, 49*4);
    chk("R2 dev0 frame", 32'(mcap[0]), 32'h005AC3);
    chk("R3 dev0 bit count", mcnt[0], 24);
    chk("R3 dev1 unselected", mcnt[1], 0);
    chk("R5 write oe", oe_bad, 0);
    chk("R6 write keeps rx", 32'(rx_data), 0);
  endtask

  task automatic t_cfg();
    set_cfg(8'd3, 2'b01);
    chk("R8 release dev0", 32'(dev_rst_n), 1);
    set_cfg(8'd3, 2'b11);
    chk("R8 release both", 32'(dev_rst_n), 3);
  endtask

  task automatic t_write_both();
    int c;
    run({2'b11, 8'h00, 8'h71, 8'h01}, c);
    chk("R3 dual dev0", 32'(mcap[0]), 32'h007101);
    chk("R3 dual dev1", 32'(mcap[1]), 32'h007101);
    chk("R4 div3 length", c, 196);
    chk("R5 dual write oe", oe_bad, 0);
  endtask

  task automatic t_read_both();
    int c;
    reply[0] = 8'hA5; reply[1] = 8'h3C;
    run({2'b11, 8'h80, 8'h5C, 8'hFF}, c);
    chk("R6 both lanes", 32'(rx_data), 32'h3CA5);
    chk("R2 read header", 32'(mcap[0][23:8]), 32'h805C);
    chk("R5 read oe", oe_bad, 0);
  endtask

  task automatic t_read_one();
    int c;
    reply[0] = 8'h11; reply[1] = 8'hE7;
    run({2'b10, 8'h80, 8'h72, 8'h00}, c);
    chk("R6 dev1 lane, dev0 lane cleared", 32'(rx_data), 32'hE700);
    chk("R3 dev0 not selected", mcnt[0], 0);
    chk("R5 single read oe", oe_bad, 0);
  endtask

  task automatic t_busy_ignore();
    int c;
    clear_model();
    exp_rnw = 1'b0;
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = {2'b01, 8'h00, 8'h10, 8'h22};
    @(negedge clk); cmd_we = 1'b0;
    c = 0;
    repeat (20) begin @(negedge clk); c++; end
    cmd_we = 1'b1; cmd_wdata = {2'b10, 8'h00, 8'h20, 8'h33};
    @(negedge clk); c++; cmd_we = 1'b0;
    while (busy) begin @(negedge clk); c++; end
    repeat (10) @(negedge clk);
    chk("R7 first frame intact", 32'(mcap[0]), 32'h001022);
    chk("R7 no second frame", mcnt[1], 0);
    chk("R7 single frame length", c, 196);
    chk("R7 idle after", 32'(busy), 0);
  endtask

  task automatic t_div();
    int c;
    set_cfg(8'd0, 2'b11);
    run({2'b01, 8'h00, 8'h44, 8'h9E}, c);
    chk("R4 div0 length", c, 49);
    chk("R2 div0 frame", 32'(mcap[0]), 32'h00449E);
    chk("R6 write keeps read result", 32'(rx_data), 32'hE700);
    set_cfg(8'd5, 2'b11);
    run({2'b10, 8'h00, 8'h0F, 8'h02}, c);
    chk("R4 div5 length", c, 294);
    chk("R2 div5 frame", 32'(mcap[1]), 32'h000F02);
    chk("R4 sclk idle low", 32'(spi_sclk), 0);
    chk("R3 cs idle high", 32'(spi_cs_n), 3);
  endtask

  initial begin
    reply[0] = '0; reply[1] = '0;
    clear_model();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_single();
    t_cfg();
    t_write_both();
    t_read_both();
    t_read_one();
    t_busy_ignore();
    t_div();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule